// File: doc/BRIEF.md
# Composite-Field AES Byte Substitution Unit

This block performs the AES SubBytes substitution on one byte. It does not use a 256-entry table. The byte is first carried by a linear bit matrix into a tower field. In that field an 8-bit element is a pair of 4-bit digits over the quadratic x^2 + x + λ, and each digit lies in GF(2^4) reduced by y^4 + y + 1. The multiplicative inverse is formed there from 4-bit multiplies, a square, a 4-bit inversion and a constant scale by λ. A second matrix brings the inverse back to the standard byte basis, and the AES affine map then gives the result.

The two matrices are not written out by hand. They are computed when the design is elaborated. The computation searches the tower field for a root of the AES reduction polynomial and builds the forward map from the powers of that root. The backward map is found by inverting the forward map column by column.

A parameter selects one of two forms. One is purely combinational. The other has a single register stage with a valid flag that travels with the data. In the registered form, the output data is held while no new input is valid.

Top module: `cf_aes_sbox`

## Requirements
- R1: For every 8-bit input, the output equals the AES S-box value: the inverse of the input under x^8+x^4+x^3+x+1, followed by the affine map with constant 0x63.
- R2: Input 0x00 is treated as having inverse 0x00, so its output is 0x63. The inner inverse of a zero tower element is zero, and a nonzero element never gives a zero inverse.
- R3: With PIPE=1, a byte presented with in_valid high appears on out_byte one clock later, with out_valid high in that cycle.
- R4: With PIPE=1, a cycle with in_valid low gives out_valid low one clock later. out_byte keeps its previous value whatever in_byte carried.
- R5: While rst_n is low (active-low, synchronous), the registered form drives out_valid = 0 and out_byte = 0x00.
- R6: With PIPE=0, out_byte is the substitution of the current in_byte in the same cycle, and out_valid equals in_valid.
- R7: Known answers that depend on a correct basis change: 0x01 gives 0x7C, 0x53 gives 0xED, and 0xFF gives 0x16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_byte as carrying a byte to substitute |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Marks out_byte as a fresh result |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench sweeps all 256 inputs through both the registered and the combinational form. It compares each result with a reference that finds the inverse by trial multiplication and applies the affine map bit by bit.

Zero is the sharpest corner. A design without the zero convention, or with a broken 4-bit inverse, would give something other than 0x63.

A wrong λ or a mismatched basis matrix would still give a bijection, but the wrong one. The fixed answers for 0x01, 0x53 and 0xFF catch it, as does the full sweep.

An idle cycle with garbage on in_byte checks that the held result is not overwritten and that the valid flag drops after one cycle.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;

    typedef logic [3:0] nib_t;
    typedef logic [7:0] byte_t;
    typedef byte_t [7:0] mat_t;   // mat[i] = image of input bit i

    localparam byte_t AFF_CONST = 8'h63;

    // GF(2^4) multiply, reduction y^4 = y + 1
    function automatic nib_t gf16_mul(nib_t a, nib_t b);
        nib_t p;
        nib_t t;
        p = '0;
        t = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) p ^= t;
            t = {t[2:0], 1'b0} ^ (t[3] ? 4'h3 : 4'h0);
        end
        return p;
    endfunction

    function automatic nib_t gf16_sq(nib_t a);
        return gf16_mul(a, a);
    endfunction

    // a^14 = a^-1 for nonzero a, 0 for a = 0
    function automatic nib_t gf16_inv(nib_t a);
        nib_t a2;
        nib_t a4;
        nib_t a8;
        a2 = gf16_sq(a);
        a4 = gf16_sq(a2);
        a8 = gf16_sq(a4);
        return gf16_mul(gf16_mul(a2, a4), a8);
    endfunction

    // Tower multiply: element = hi*x + lo, x^2 = x + lam
    function automatic byte_t cf_mul(byte_t a, byte_t b, nib_t lam);
        nib_t hh;
        nib_t hi;
        nib_t lo;
        hh = gf16_mul(a[7:4], b[7:4]);
        hi = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
        lo = gf16_mul(hh, lam) ^ gf16_mul(a[3:0], b[3:0]);
        return {hi, lo};
    endfunction

    // Tower element that satisfies the AES reduction polynomial
    function automatic byte_t find_root(nib_t lam);
        byte_t c;
        byte_t c2;
        byte_t c3;
        byte_t c4;
        byte_t c8;
        for (int v = 2; v < 256; v++) begin
            c  = byte_t'(v);
            c2 = cf_mul(c, c, lam);
            c3 = cf_mul(c2, c, lam);
            c4 = cf_mul(c2, c2, lam);
            c8 = cf_mul(c4, c4, lam);
            if ((c8 ^ c4 ^ c3 ^ c ^ 8'h01) == 8'h00) return c;
        end
        return 8'h00;
    endfunction

    function automatic byte_t mat_apply(mat_t m, byte_t v);
        byte_t r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) r ^= m[i];
        end
        return r;
    endfunction

    function automatic mat_t build_fwd(nib_t lam);
        mat_t m;
        byte_t beta;
        byte_t p;
        beta = find_root(lam);
        p    = 8'h01;
        for (int i = 0; i < 8; i++) begin
            m[i] = p;
            p    = cf_mul(p, beta, lam);
        end
        return m;
    endfunction

    function automatic mat_t build_bwd(mat_t fwd);
        mat_t m;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            for (int v = 0; v < 256; v++) begin
                if (mat_apply(fwd, byte_t'(v)) == (8'h01 << j)) m[j] = byte_t'(v);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/cf_lin_map.sv
module cf_lin_map
    import aes_cf_pkg::*;
#(
    parameter mat_t MATRIX = '0
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] terms [8];

    for (genvar i = 0; i < 8; i++) begin : g_col
        assign terms[i] = din[i] ? MATRIX[i] : 8'h00;
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < 8; i++) dout ^= terms[i];
    end
endmodule

// File: rtl/cf_inverter.sv
module cf_inverter
    import aes_cf_pkg::*;
#(
    parameter logic [3:0] LAMBDA = 4'hC
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    nib_t ah;
    nib_t al;
    nib_t sum_d;
    nib_t delta_d;
    nib_t dinv_d;

    always_comb begin
        ah      = din[7:4];
        al      = din[3:0];
        sum_d   = ah ^ al;
        delta_d = gf16_mul(sum_d, al) ^ gf16_mul(LAMBDA, gf16_sq(ah));
        dinv_d  = gf16_inv(delta_d);
        dout    = {gf16_mul(ah, dinv_d), gf16_mul(sum_d, dinv_d)};
    end
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
    import aes_cf_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    always_comb begin
        dout = din
             ^ {din[6:0], din[7]}
             ^ {din[5:0], din[7:6]}
             ^ {din[4:0], din[7:5]}
             ^ {din[3:0], din[7:4]}
             ^ AFF_CONST;
    end
endmodule

// File: rtl/cf_aes_sbox.sv
module cf_aes_sbox
    import aes_cf_pkg::*;
#(
    parameter int         PIPE   = 1,
    parameter logic [3:0] LAMBDA = 4'hC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    localparam mat_t FWD = build_fwd(LAMBDA);
    localparam mat_t BWD = build_bwd(FWD);

    logic [7:0] cf_fwd;
    logic [7:0] cf_inv;
    logic [7:0] inv_byte;
    logic [7:0] sub_byte;

    cf_lin_map #(.MATRIX(FWD)) u_to_cf (
        .din (in_byte),
        .dout(cf_fwd)
    );

    cf_inverter #(.LAMBDA(LAMBDA)) u_inv (
        .din (cf_fwd),
        .dout(cf_inv)
    );

    cf_lin_map #(.MATRIX(BWD)) u_from_cf (
        .din (cf_inv),
        .dout(inv_byte)
    );

    sbox_affine u_aff (
        .din (inv_byte),
        .dout(sub_byte)
    );

    if (PIPE != 0) begin : g_reg
        typedef struct packed {
            logic       vld;
            logic [7:0] dat;
        } stage_t;

        stage_t stage_d;
        stage_t stage_q;

        always_comb begin
            stage_d     = stage_q;
            stage_d.vld = in_valid;
            if (in_valid) stage_d.dat = sub_byte;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end

        assign out_valid = stage_q.vld;
        assign out_byte  = stage_q.dat;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_byte  = sub_byte;
    end
endmodule

// File: rtl/cf_aes_sbox_chk.sv
module cf_aes_sbox_chk #(
    parameter int PIPE = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic [7:0] cf_fwd,
    input logic [7:0] cf_inv
);
    a_r2_zero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_fwd == 8'h00) |-> (cf_inv == 8'h00));

    a_r2_nonzero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_fwd != 8'h00) |-> (cf_inv != 8'h00));

    if (PIPE != 0) begin : g_seq
        a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_byte));

        a_r2_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte == 8'h00) |=> (out_byte == 8'h63));
    end
endmodule

bind cf_aes_sbox cf_aes_sbox_chk #(.PIPE(PIPE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .out_valid(out_valid),
    .out_byte (out_byte),
    .cf_fwd   (cf_fwd),
    .cf_inv   (cf_inv)
);

// File: tb/cf_aes_sbox_test.sv
`timescale 1ns/1ps
module cf_aes_sbox_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       c_valid = 1'b0;
    logic [7:0] c_byte = 8'h00;
    logic       c_out_valid;
    logic [7:0] c_out_byte;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cf_aes_sbox #(.PIPE(1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    cf_aes_sbox #(.PIPE(0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_byte(c_byte),
        .out_valid(c_out_valid), .out_byte(c_out_byte)
    );

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p;
        logic [7:0] t;
        p = 8'h00;
        t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= t;
            t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_sbox(logic [7:0] x);
        logic [7:0] inv;
        logic [7:0] r;
        logic [7:0] c;
        inv = 8'h00;
        for (int y = 1; y < 256; y++) begin
            if (ref_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        end
        c = 8'h63;
        for (int i = 0; i < 8; i++) begin
            r[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8]
                 ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ c[i];
        end
        return r;
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state of the registered form
        check("R5", "out_valid in reset", {7'd0, out_valid}, 8'h00);
        check("R5", "out_byte in reset", out_byte, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i > 0) begin
                // R3: previous byte appears one cycle later
                check("R3", "out_valid", {7'd0, out_valid}, 8'h01);
                check("R1", "registered sweep", out_byte, ref_sbox(8'(i - 1)));
            end
            in_valid = 1'b1;
            in_byte  = 8'(i);
            c_valid  = 1'b1;
            c_byte   = 8'(i);
            #1;
            // R6: combinational form, same cycle
            check("R6", "comb sweep", c_out_byte, ref_sbox(8'(i)));
            check("R6", "comb valid", {7'd0, c_out_valid}, 8'h01);
            if (i == 0)    check("R2", "zero input comb", c_out_byte, 8'h63);
            if (i == 1)    check("R7", "0x01 comb", c_out_byte, 8'h7C);
            if (i == 8'h53) check("R7", "0x53 comb", c_out_byte, 8'hED);
        end
        @(negedge clk);
        check("R7", "0xFF registered", out_byte, 8'h16);
        check("R3", "out_valid last", {7'd0, out_valid}, 8'h01);

        // R4: idle cycle with garbage on in_byte
        in_valid = 1'b0;
        in_byte  = 8'hAA;
        c_valid  = 1'b0;
        #1;
        check("R6", "comb valid mirrors low", {7'd0, c_out_valid}, 8'h00);
        @(negedge clk);
        check("R4", "out_valid idle", {7'd0, out_valid}, 8'h00);
        check("R4", "out_byte held", out_byte, 8'h16);
        @(negedge clk);
        check("R4", "out_byte still held", out_byte, 8'h16);

        // R2: zero through the registered path after idle
        in_valid = 1'b1;
        in_byte  = 8'h00;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "zero input registered", out_byte, 8'h63);

        // R5: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R5", "out_byte after reset", out_byte, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule